// File: doc/BRIEF.md
# Three-Bit Lookahead Data Scrambler

This block whitens the payload bit stream of an OFDM wireless LAN transmitter three bits at a time. A 7-bit linear feedback register produces a pseudo-random keystream from the polynomial x^7 + x^4 + 1. Each transfer XORs three consecutive payload bits with three consecutive keystream bits. All three keystream bits come from the register contents present at the start of the cycle, and the register then moves forward by three positions. A one-bit-per-clock scrambler would need three clocks for the same work.

Software or the framing logic writes a seed through a small load port. A frame start strobe copies that seed into the running register, so every frame begins from a known point. Payload enters through a 3-bit valid/ready input and leaves through a registered 3-bit valid/ready output. Every supported count of data bits per OFDM symbol is a multiple of three, so the block never handles a partial group.

Top module: `ofdm_scrambler3`

## Requirements
- R1: After reset the output holds no data (`out_valid` low, `in_ready` high). Both the running register and the stored seed hold all ones.
- R2: With register bits named x7 (bit 6) down to x1 (bit 0), one serial step computes k = x7 XOR x4. It then shifts the register towards x7 and puts k into x1. The three keystream bits of a transfer equal three such serial steps taken in order.
- R3: `in_data[0]` is the earliest bit in time of a group. Output bit i equals `in_data[i]` XOR keystream bit i, where keystream bit 0 is the first serial step.
- R4: The register advances by exactly three serial steps on each accepted transfer (`in_valid` and `in_ready` both high). At all other times it keeps its value, unless a frame start reloads it.
- R5: A seed write (`seed_wr` high) stores `seed_val` from the next cycle onward. A write of zero is rejected and stores all ones instead. A seed write alone leaves the running register and the output stream unchanged.
- R6: A frame start copies the stored seed into the register. If a transfer is accepted in the same cycle, that transfer already uses the seed as its starting state.
- R7: `in_ready` is high exactly when the output stage is empty or being drained. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R8: The keystream repeats with a period of 127 bits, and each 127-bit period contains 64 ones.
- R9: The running register is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_wr | input | 1 | Store `seed_val` as the frame seed |
| seed_val | input | 7 | Seed value, bit 6 = x7 |
| frame_start | input | 1 | Reload the register from the stored seed |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block accepts a group this cycle |
| in_data | input | 3 | Payload group, bit 0 earliest |
| out_valid | output | 1 | Scrambled group present |
| out_ready | input | 1 | Sink accepts the output group |
| out_data | output | 3 | Scrambled group, bit 0 earliest |

## Verification
A wrong register state or tap shows up as wrong scrambled bits in the very group that follows. The register is never read directly, so the scoreboard compares every group against a bit-serial model and reports the fault on the first output handshake after it occurs. A wrong bit order inside a group shows up at once as swapped bits, provided the keystream bits of that group differ. Seed and period faults are found by starting frames from known seeds and by measuring the 127-bit repetition of the stream produced from zero payload.

// File: rtl/scr3_pkg.sv
// Shared constants for the three-bit scrambler.
// Assumes a 7-bit register with taps at delays 7 and 4.
package scr3_pkg;
    localparam int STATE_W = 7;
    localparam int TAP_HI  = 7;
    localparam int TAP_LO  = 4;
    localparam int GROUP   = 3;
    localparam logic [STATE_W-1:0] SAFE_SEED = {STATE_W{1'b1}};
endpackage

// File: rtl/scr3_lookahead.sv
// Combinational lookahead: unrolls GROUP serial steps of the register.
// Assumes GROUP <= STATE_W - TAP_LO + 1, so no step reads a bit fed back in the same group.
module scr3_lookahead #(
    parameter int STATE_W = 7,
    parameter int TAP_HI  = 7,
    parameter int TAP_LO  = 4,
    parameter int GROUP   = 3
) (
    input  logic [STATE_W-1:0] st_i,
    output logic [GROUP-1:0]   ks_o,
    output logic [STATE_W-1:0] st_next_o
);
    // Purpose: take GROUP serial steps starting from a single snapshot of the state.
    always_comb begin
        logic [STATE_W-1:0] w;
        logic               fb;
        w = st_i;
        ks_o = '0;
        for (int i = 0; i < GROUP; i++) begin
            fb      = w[TAP_HI-1] ^ w[TAP_LO-1];
            ks_o[i] = fb;
            w       = {w[STATE_W-2:0], fb};
        end
        st_next_o = w;
    end
endmodule

// File: rtl/scr3_seed_reg.sv
// Holds the frame seed. A zero write is replaced with the safe all-ones value.
// Assumes a synchronous active-low reset.
module scr3_seed_reg #(
    parameter int STATE_W = 7,
    parameter logic [STATE_W-1:0] SAFE_SEED = {STATE_W{1'b1}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [STATE_W-1:0] val_i,
    output logic [STATE_W-1:0] seed_o
);
    logic [STATE_W-1:0] seed_q;

    // Purpose: capture a non-zero seed on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seed_q <= SAFE_SEED;
        else if (wr_i)
            seed_q <= (val_i == '0) ? SAFE_SEED : val_i;
    end

    assign seed_o = seed_q;

    // R5
    seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (seed_q != '0));

    // R5
    seed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(seed_q));
endmodule

// File: rtl/scr3_out_stage.sv
// One-entry registered output stage with valid/ready.
// Assumes the producer loads only when free_o is high.
module scr3_out_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic         free_o,
    output logic         out_valid_o,
    input  logic         out_ready_i,
    output logic [W-1:0] out_data_o
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign free_o = !vld_q || out_ready_i;

    // Purpose: track whether the stage holds a group.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else if (load_i)
            vld_q <= 1'b1;
        else if (out_ready_i)
            vld_q <= 1'b0;
    end

    // Purpose: capture new scrambled data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dat_q <= '0;
        else if (load_i)
            dat_q <= data_i;
    end

    assign out_valid_o = vld_q;
    assign out_data_o  = dat_q;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !out_ready_i) |=> (vld_q && $stable(dat_q)));

    // R7
    load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> free_o);
endmodule

// File: rtl/ofdm_scrambler3.sv
// Three-bit-per-clock additive scrambler with seed load and frame restart.
// Assumes in_data[0] is the earliest bit of each group and that frames carry whole groups.
module ofdm_scrambler3
    import scr3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_wr,
    input  logic [STATE_W-1:0] seed_val,
    input  logic               frame_start,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [GROUP-1:0]   in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [GROUP-1:0]   out_data
);
    logic [STATE_W-1:0] seed;
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] cur_state;
    logic [STATE_W-1:0] adv_state;
    logic [GROUP-1:0]   ks;
    logic               fire;

    scr3_seed_reg #(.STATE_W(STATE_W), .SAFE_SEED(SAFE_SEED)) i_seed (
        .clk(clk), .rst_n(rst_n), .wr_i(seed_wr), .val_i(seed_val), .seed_o(seed)
    );

    // Purpose: a frame start makes the seed the starting state of this cycle.
    assign cur_state = frame_start ? seed : state_q;

    scr3_lookahead #(.STATE_W(STATE_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .GROUP(GROUP)) i_look (
        .st_i(cur_state), .ks_o(ks), .st_next_o(adv_state)
    );

    scr3_out_stage #(.W(GROUP)) i_out (
        .clk(clk), .rst_n(rst_n), .load_i(fire), .data_i(in_data ^ ks),
        .free_o(in_ready), .out_valid_o(out_valid), .out_ready_i(out_ready),
        .out_data_o(out_data)
    );

    assign fire = in_valid && in_ready;

    // Purpose: advance on transfer, reload on frame start, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SAFE_SEED;
        else if (fire)
            state_q <= adv_state;
        else if (frame_start)
            state_q <= seed;
    end

    // R9
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R4
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !frame_start) |=> $stable(state_q));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !fire) |=> (state_q == $past(seed)));

    // R7
    fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);
endmodule

// File: tb/test_ofdm_scrambler3.sv
module test_ofdm_scrambler3;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seed_wr = 1'b0;
    logic [6:0] seed_val = '0;
    logic       frame_start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_data = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [2:0] out_data;

    int errors = 0;
    int checks = 0;
    logic [6:0] ref_st = 7'h7F;
    logic [6:0] ref_seed = 7'h7F;
    logic [2:0] exp_q[$];
    logic [2:0] tag_q[$];
    bit   rand_ready = 0;
    bit   capture = 0;
    int   cap_n = 0;
    logic ks_bits[381];
    int   cyc = 0;

    always #5 clk = ~clk;

    ofdm_scrambler3 i_ofdm_scrambler3 (
        .clk(clk), .rst_n(rst_n), .seed_wr(seed_wr), .seed_val(seed_val),
        .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial model: one step, returns the keystream bit.
    function automatic logic ref_step();
        logic k;
        k = ref_st[6] ^ ref_st[3];
        ref_st = {ref_st[5:0], k};
        return k;
    endfunction

    task automatic send(input logic [2:0] d, input bit fs, input logic [2:0] req);
        logic [2:0] ks;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; frame_start = fs;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        if (fs) ref_st = ref_seed;
        for (int i = 0; i < 3; i++) ks[i] = ref_step();
        exp_q.push_back(d ^ ks);
        tag_q.push_back(req);
        @(posedge clk);
        #1 in_valid = 1'b0; frame_start = 1'b0;
    endtask

    task automatic write_seed(input logic [6:0] v);
        @(negedge clk);
        seed_wr = 1'b1; seed_val = v;
        @(posedge clk);
        #1 seed_wr = 1'b0;
        ref_seed = (v == 7'h00) ? 7'h7F : v;
    endtask

    task automatic start_alone();
        @(negedge clk);
        frame_start = 1'b1;
        @(posedge clk);
        #1 frame_start = 1'b0;
        ref_st = ref_seed;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Sink readiness: changes well after the rising edge.
    always @(posedge clk) begin
        #2 out_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    // Monitor: pops expected groups and compares on each output handshake.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && !out_ready)
            check(in_ready == 1'b0, "R7 stall blocks input", in_ready, 0);
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected output", out_data, 0);
            end else begin
                logic [2:0] e;
                logic [2:0] t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data == e, $sformatf("R%0d data", t), out_data, e);
                if (capture && cap_n < 381) begin
                    for (int i = 0; i < 3; i++) ks_bits[cap_n + i] = out_data[i];
                    cap_n += 3;
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty output stage after reset
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        // R1 R2 R3: first groups from all-ones reset state, several patterns
        send(3'b000, 0, 1);
        send(3'b001, 0, 3);
        send(3'b100, 0, 3);
        send(3'b111, 0, 2);
        send(3'b010, 0, 3);
        drain();
        // R5: seed write alone leaves the running stream unaffected
        write_seed(7'h2C);
        send(3'b000, 0, 5);
        send(3'b101, 0, 5);
        drain();
        // R6: frame start alone, then data
        start_alone();
        send(3'b000, 0, 6);
        send(3'b110, 0, 6);
        // R6: frame start in the same cycle as a transfer
        write_seed(7'h41);
        send(3'b011, 1, 6);
        send(3'b000, 0, 6);
        drain();
        // R5: zero seed rejected, all ones used instead
        write_seed(7'h00);
        send(3'b000, 1, 5);
        send(3'b000, 0, 5);
        drain();
        // R4 R7: random backpressure over a long run
        rand_ready = 1;
        for (int n = 0; n < 60; n++) send(3'(n * 5 + 1), (n == 30), 4);
        drain();
        rand_ready = 0;
        // R8: period of the keystream from zero payload
        write_seed(7'h5A);
        capture = 1;
        cap_n = 0;
        for (int n = 0; n < 127; n++) send(3'b000, (n == 0), 8);
        drain();
        capture = 0;
        begin
            int mism;
            int ones;
            mism = 0;
            ones = 0;
            for (int n = 0; n < 254; n++) if (ks_bits[n] != ks_bits[n + 127]) mism++;
            for (int n = 0; n < 127; n++) if (ks_bits[n]) ones++;
            check(mism == 0, "R8 period 127", mism, 0);
            check(ones == 64, "R8 ones per period", ones, 64);
        end
        // R9: stream after all of the above still not stuck at zero state
        send(3'b000, 0, 9);
        drain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule